// File: doc/BRIEF.md
# DDR Write Burst Strobe Capture

This block is the receive side of a DDR write path. It watches the command inputs for a write, then collects one burst of data words off the data strobe. The first word is taken on the first rising strobe edge after the command. Each later word is taken on the next strobe edge, so the edges alternate falling, rising, falling. The collected words and their per-byte mask flags are presented as two flat vectors. A one-sample done pulse, aligned to the memory clock, marks the end of the burst.

All logic runs on a sampling clock at four times the memory clock rate. A phase counter tracks where the memory clock's rising edge falls within each group of four samples, and the write command is only taken on that phase. A quarter-cycle timer, restarted by the command, checks when the first rising strobe edge arrives. An edge seen too early (inside the preamble) or not seen in time raises a window-error flag, and the burst is abandoned. Once the burst is finished, strobe and data activity changes nothing until the next write is taken.

Top module: `ddr_wr_capture`

## Requirements
- R1: After reset, `burst_data`, `burst_mask`, `burst_done` and `win_err` are all zero.
- R2: A write is taken only on a sample where `cmd_valid` and `cmd_write` are both high, the phase counter is 0 (the memory-clock-aligned sample; phase 0 is the first sample after reset and every fourth sample after it) and no burst is in progress. A read (`cmd_write` low) or a command on any other phase is ignored.
- R3: The first word is captured from `dq` on the first sample that sees `dqs` high after a low sample, provided that sample is 3, 4 or 5 quarter-cycles after the command sample. It lands in `burst_data[DQ_W-1:0]`.
- R4: Word k (k = 1 to BURST-1) is captured on the k-th strobe transition after the first rising edge and lands in `burst_data[k*DQ_W +: DQ_W]`.
- R5: `burst_mask[k*DM_W + b]` is 1 when `dm[b]` was high as word k was captured, and 0 otherwise.
- R6: A rising strobe edge seen 1 or 2 quarter-cycles after the command (during the preamble) sets `win_err`, captures nothing and returns the block to idle.
- R7: If no rising strobe edge has been seen by 5 quarter-cycles after the command, `win_err` is set and the block returns to idle without capturing.
- R8: After the last word, `burst_done` is high for exactly one sample period. It is seen high on the first phase-0 sample that follows the last capture by at least one sample.
- R9: `win_err` stays set until the next accepted write clears it. A failed command raises no done pulse.
- R10: While idle, including after a finished burst, strobe, data and mask activity leaves `burst_data` and `burst_mask` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_q | input | 1 | Sampling clock, four times the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | Command is a write |
| dqs | input | 1 | Data strobe |
| dq | input | DQ_W | Data lanes |
| dm | input | DM_W | Byte mask, one bit per byte lane |
| burst_data | output | BURST*DQ_W | Captured words, word 0 in the low bits |
| burst_mask | output | BURST*DM_W | Masked-lane flags per word |
| burst_done | output | 1 | One-sample pulse at burst completion |
| win_err | output | 1 | First strobe edge fell outside the window |

## Verification
The bound checker covers the behaviour that can be seen on every sample:
- done is a single-sample pulse that falls on phase 0;
- the capture sequence only starts from a phase-0 write;
- the error flag only rises while waiting for the first strobe edge;
- captured data holds still while the block is idle.

The arrival delays, the capture order and lane placement of each word, and the mask flags need whole burst scenarios. So do the exact done sample and the early and late strobe cases. The bench provides these, using random data, random masks and random delays inside the window, plus directed out-of-window, read and off-phase commands.

// File: rtl/ddrwc_pkg.sv
package ddrwc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_CAPT = 2'd2,
      ST_FIN  = 2'd3
   } cap_state_t;
endpackage

// File: rtl/ddrwc_phase.sv
// Memory-clock phase tracker and quarter-cycle timer since the last command.
module ddrwc_phase #(
   parameter int Q_PER_CK = 4,
   parameter int PH_W     = $clog2(Q_PER_CK),
   parameter int Q_W      = 3
) (
   input  logic            clk_q,
   input  logic            rst_n,
   input  logic            start,
   output logic [PH_W-1:0] ph,
   output logic [Q_W-1:0]  q
);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(Q_PER_CK - 1);

   always_ff @(posedge clk_q or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (ph == PH_LAST) begin
         ph <= '0;
      end else begin
         ph <= ph + 1'b1;
      end
   end

   // q equals the number of samples elapsed since the command sample
   always_ff @(posedge clk_q or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (start) begin
         q <= Q_W'(1);
      end else if (q != '1) begin
         q <= q + 1'b1;
      end
   end
endmodule

// File: rtl/ddrwc_strobe.sv
// Strobe edge detector on the oversampled strobe.
module ddrwc_strobe (
   input  logic clk_q,
   input  logic rst_n,
   input  logic dqs,
   output logic rise,
   output logic toggle
);
   logic dqs_prev;

   always_ff @(posedge clk_q or negedge rst_n) begin
      if (!rst_n) begin
         dqs_prev <= 1'b0;
      end else begin
         dqs_prev <= dqs;
      end
   end

   assign rise   = dqs & ~dqs_prev;
   assign toggle = dqs ^ dqs_prev;
endmodule

// File: rtl/ddrwc_bank.sv
// Per-word holding registers for one burst.
module ddrwc_bank #(
   parameter int BURST = 4,
   parameter int DQ_W  = 16,
   parameter int DM_W  = 2,
   parameter int IDX_W = $clog2(BURST)
) (
   input  logic                  clk_q,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      idx,
   input  logic [DQ_W-1:0]       dq,
   input  logic [DM_W-1:0]       dm,
   output logic [BURST*DQ_W-1:0] data,
   output logic [BURST*DM_W-1:0] mask
);
   for (genvar i = 0; i < BURST; i++) begin : g_word
      logic [DQ_W-1:0] w_q;
      logic [DM_W-1:0] m_q;

      always_ff @(posedge clk_q or negedge rst_n) begin
         if (!rst_n) begin
            w_q <= '0;
            m_q <= '0;
         end else if (wr_en && (idx == IDX_W'(i))) begin
            w_q <= dq;
            m_q <= dm;
         end
      end

      assign data[i*DQ_W +: DQ_W] = w_q;
      assign mask[i*DM_W +: DM_W] = m_q;
   end
endmodule

// File: rtl/ddr_wr_capture.sv
// DDR write burst capture on an oversampled strobe.
module ddr_wr_capture
   import ddrwc_pkg::*;
#(
   parameter int BURST    = 4,
   parameter int DQ_W     = 16,
   parameter int Q_PER_CK = 4,
   parameter int WIN_LO   = 3,
   parameter int WIN_HI   = 5,
   parameter int DM_W     = DQ_W / 8
) (
   input  logic                  clk_q,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic                  cmd_write,
   input  logic                  dqs,
   input  logic [DQ_W-1:0]       dq,
   input  logic [DM_W-1:0]       dm,
   output logic [BURST*DQ_W-1:0] burst_data,
   output logic [BURST*DM_W-1:0] burst_mask,
   output logic                  burst_done,
   output logic                  win_err
);
   localparam int PH_W  = $clog2(Q_PER_CK);
   localparam int IDX_W = $clog2(BURST);
   localparam int Q_W   = $clog2(WIN_HI + 2);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BURST - 1);
   localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(Q_PER_CK - 1);

   if (DQ_W % 8 != 0) begin : g_bad_dq
      $error("DQ_W must be a whole number of bytes");
   end
   if (DM_W != DQ_W / 8) begin : g_bad_dm
      $error("DM_W must give one mask bit per byte");
   end
   if (BURST < 2 || BURST % 2 != 0 || (BURST & (BURST - 1)) != 0) begin : g_bad_burst
      $error("BURST must be an even power of two");
   end
   if (Q_PER_CK < 2 || (Q_PER_CK & (Q_PER_CK - 1)) != 0) begin : g_bad_q
      $error("Q_PER_CK must be a power of two of at least 2");
   end
   if (WIN_LO < 2 || WIN_HI < WIN_LO) begin : g_bad_win
      $error("window bounds must satisfy 2 <= WIN_LO <= WIN_HI");
   end

   cap_state_t       st;
   logic [PH_W-1:0]  ph;
   logic [Q_W-1:0]   q;
   logic [IDX_W-1:0] idx;
   logic             rise, toggle;
   logic             accept, in_win, first_hit, cap_en;
   logic [IDX_W-1:0] cap_idx;

   assign accept    = (st == ST_IDLE) && cmd_valid && cmd_write && (ph == '0);
   assign in_win    = (q >= Q_W'(WIN_LO)) && (q <= Q_W'(WIN_HI));
   assign first_hit = (st == ST_WAIT) && rise && in_win;
   assign cap_en    = first_hit || ((st == ST_CAPT) && toggle);
   assign cap_idx   = (st == ST_WAIT) ? '0 : idx;

   ddrwc_phase #(.Q_PER_CK(Q_PER_CK), .PH_W(PH_W), .Q_W(Q_W)) i_phase (
      .clk_q (clk_q),
      .rst_n (rst_n),
      .start (accept),
      .ph    (ph),
      .q     (q)
   );

   ddrwc_strobe i_strobe (
      .clk_q  (clk_q),
      .rst_n  (rst_n),
      .dqs    (dqs),
      .rise   (rise),
      .toggle (toggle)
   );

   ddrwc_bank #(.BURST(BURST), .DQ_W(DQ_W), .DM_W(DM_W), .IDX_W(IDX_W)) i_bank (
      .clk_q (clk_q),
      .rst_n (rst_n),
      .wr_en (cap_en),
      .idx   (cap_idx),
      .dq    (dq),
      .dm    (dm),
      .data  (burst_data),
      .mask  (burst_mask)
   );

   always_ff @(posedge clk_q or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         idx        <= '0;
         win_err    <= 1'b0;
         burst_done <= 1'b0;
      end else begin
         burst_done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  st      <= ST_WAIT;
                  win_err <= 1'b0;
               end
            end
            ST_WAIT: begin
               if (first_hit) begin
                  st  <= ST_CAPT;
                  idx <= IDX_W'(1);
               end else if (rise || (q >= Q_W'(WIN_HI))) begin
                  st      <= ST_IDLE;
                  win_err <= 1'b1;
               end
            end
            ST_CAPT: begin
               if (toggle) begin
                  idx <= idx + 1'b1;
                  if (idx == IDX_LAST) begin
                     st <= ST_FIN;
                  end
               end
            end
            ST_FIN: begin
               if (ph == PH_LAST) begin
                  st         <= ST_IDLE;
                  burst_done <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ddrwc_chk.sv
// Cycle-level properties of the capture block, attached by bind.
module ddrwc_chk
   import ddrwc_pkg::*;
#(
   parameter int PH_W   = 2,
   parameter int DATA_W = 64
) (
   input logic              clk_q,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_write,
   input logic [PH_W-1:0]   ph,
   input cap_state_t        st,
   input logic              burst_done,
   input logic              win_err,
   input logic [DATA_W-1:0] burst_data
);
   // R8
   done_pulse_chk: assert property (@(posedge clk_q) disable iff (!rst_n)
      burst_done |=> !burst_done);

   // R8
   done_phase_chk: assert property (@(posedge clk_q) disable iff (!rst_n)
      burst_done |-> (ph == '0));

   // R2
   accept_chk: assert property (@(posedge clk_q) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) == ST_IDLE) |-> $past(cmd_valid && cmd_write && ph == '0));

   // R6 R7
   err_src_chk: assert property (@(posedge clk_q) disable iff (!rst_n)
      $rose(win_err) |-> ($past(st) == ST_WAIT));

   // R9
   done_clean_chk: assert property (@(posedge clk_q) disable iff (!rst_n)
      $rose(burst_done) |-> !win_err);

   // R10
   idle_hold_chk: assert property (@(posedge clk_q) disable iff (!rst_n)
      (st == ST_IDLE && $past(st) == ST_IDLE) |-> $stable(burst_data));
endmodule

bind ddr_wr_capture ddrwc_chk #(.PH_W(PH_W), .DATA_W(BURST*DQ_W)) i_chk (
   .clk_q      (clk_q),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_write  (cmd_write),
   .ph         (ph),
   .st         (st),
   .burst_done (burst_done),
   .win_err    (win_err),
   .burst_data (burst_data)
);

// File: tb/test_ddr_wr_capture.sv
module test_ddr_wr_capture;
   localparam int CLK_PERIOD = 10;
   localparam int BURST  = 4;
   localparam int DQ_W   = 16;
   localparam int DM_W   = DQ_W / 8;
   localparam int DATA_W = BURST * DQ_W;
   localparam int MASK_W = BURST * DM_W;

   logic              clk_q = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_write = 1'b0;
   logic              dqs = 1'b0;
   logic [DQ_W-1:0]   dq = '0;
   logic [DM_W-1:0]   dm = '0;
   logic [DATA_W-1:0] burst_data;
   logic [MASK_W-1:0] burst_mask;
   logic              burst_done;
   logic              win_err;

   int n_total = 0;
   int n_fail  = 0;
   int edge_n  = 0;

   logic [DATA_W-1:0] exp_data = '0;
   logic [MASK_W-1:0] exp_mask = '0;
   logic              exp_err  = 1'b0;

   ddr_wr_capture i_ddr_wr_capture (
      .clk_q      (clk_q),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_write  (cmd_write),
      .dqs        (dqs),
      .dq         (dq),
      .dm         (dm),
      .burst_data (burst_data),
      .burst_mask (burst_mask),
      .burst_done (burst_done),
      .win_err    (win_err)
   );

   always #(CLK_PERIOD / 2) clk_q = ~clk_q;

   // index of the next sampling edge, counted from the first edge out of reset
   always @(posedge clk_q) if (rst_n) edge_n++;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // sample index (relative to the command) on which done must be seen
   function automatic int done_offset(input int d);
      int o = d + 7;
      while (o % 4 != 3) o++;
      return o;
   endfunction

   function automatic bit in_window(input int d);
      return (d >= 3) && (d <= 5);
   endfunction

   task automatic run_burst(input int ph_off, input bit wr, input int d,
                            input logic [DATA_W-1:0] words, input logic [MASK_W-1:0] dms,
                            input string req);
      bit ok, taken;
      int o, done_bad, k;
      logic exp_d;
      taken = wr && (ph_off == 0);
      ok    = taken && in_window(d);
      o     = done_offset(d);
      done_bad = 0;
      do @(negedge clk_q); while ((edge_n % 4) != ph_off);
      for (int rel = 0; rel < 24; rel++) begin
         if (rel > 0) begin
            @(negedge clk_q);
            exp_d = ok && (rel - 1 == o);
            if (burst_done !== exp_d) done_bad++;
         end
         cmd_valid = (rel == 0);
         cmd_write = wr;
         if (rel < d) begin
            dqs = 1'b0;
            dq  = DQ_W'($urandom);
            dm  = DM_W'($urandom);
         end else if (rel < d + 2 * BURST) begin
            k   = (rel - d) / 2;
            dqs = (k % 2 == 0);
            dq  = words[k*DQ_W +: DQ_W];
            dm  = dms[k*DM_W +: DM_W];
         end else begin
            dqs = (rel >= d + 10) ? rel[0] : 1'b0;
            dq  = DQ_W'($urandom);
            dm  = DM_W'($urandom);
         end
      end
      @(negedge clk_q);
      cmd_valid = 1'b0;
      cmd_write = 1'b0;
      dqs = 1'b0;
      if (ok) begin
         exp_data = words;
         exp_mask = dms;
         exp_err  = 1'b0;
      end else if (taken) begin
         exp_err = 1'b1;
      end
      chk(burst_data === exp_data, req, "burst words", burst_data, exp_data);
      chk(burst_mask === exp_mask, req, "byte masks", DATA_W'(burst_mask), DATA_W'(exp_mask));
      chk(win_err === exp_err, req, "window error", DATA_W'(win_err), DATA_W'(exp_err));
      chk(done_bad == 0, req, "done pulse timing", DATA_W'(done_bad), '0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      void'($urandom(32'h0DD5_1EED));
      repeat (3) @(negedge clk_q);
      // R1 reset state
      chk(burst_data === '0, "R1", "reset data", burst_data, '0);
      chk(burst_mask === '0, "R1", "reset mask", DATA_W'(burst_mask), '0);
      chk(burst_done === 1'b0, "R1", "reset done", DATA_W'(burst_done), '0);
      chk(win_err === 1'b0, "R1", "reset error", DATA_W'(win_err), '0);
      rst_n = 1'b1;

      // R3 R4 R5 R8 directed: edge at each window boundary, alternating masks
      run_burst(0, 1'b1, 3, 64'h1111_2222_3333_4444, 8'b10_01_11_00, "R3");
      run_burst(0, 1'b1, 5, 64'hA5A5_5A5A_0F0F_F0F0, 8'b01_10_00_11, "R4");
      run_burst(0, 1'b1, 4, 64'hFFFF_0000_FFFF_0000, 8'b11_11_11_11, "R5");

      // R6 preamble violation, R9 error held, then cleared by a good write
      run_burst(0, 1'b1, 2, 64'hDEAD_BEEF_CAFE_F00D, 8'h5A, "R6");
      run_burst(0, 1'b1, 6, 64'h0123_4567_89AB_CDEF, 8'hC3, "R7");
      run_burst(0, 1'b0, 4, 64'h7777_8888_9999_AAAA, 8'h0F, "R9");
      run_burst(0, 1'b1, 4, 64'h1357_9BDF_2468_ACE0, 8'h96, "R9");

      // R2 ignored commands: read, off-phase write
      run_burst(0, 1'b0, 4, 64'hBAD0_BAD1_BAD2_BAD3, 8'hFF, "R2");
      run_burst(1, 1'b1, 4, 64'hBAD4_BAD5_BAD6_BAD7, 8'hFF, "R2");
      run_burst(2, 1'b1, 3, 64'hBAD8_BAD9_BADA_BADB, 8'hFF, "R2");

      // R10 idle activity after a finished burst leaves the result alone
      repeat (20) begin
         @(negedge clk_q);
         dqs = ~dqs;
         dq  = DQ_W'($urandom);
         dm  = DM_W'($urandom);
      end
      @(negedge clk_q);
      dqs = 1'b0;
      @(negedge clk_q);
      chk(burst_data === exp_data, "R10", "idle data hold", burst_data, exp_data);
      chk(burst_mask === exp_mask, "R10", "idle mask hold", DATA_W'(burst_mask), DATA_W'(exp_mask));
      chk(burst_done === 1'b0, "R10", "idle no done", DATA_W'(burst_done), '0);

      // random mix: mostly in-window writes, some out-of-window and ignored
      for (int n = 0; n < 40; n++) begin
         int sel, d, pho;
         bit wr;
         logic [DATA_W-1:0] w;
         logic [MASK_W-1:0] m;
         sel = int'($urandom % 10);
         d   = 3 + int'($urandom % 3);
         wr  = 1'b1;
         pho = 0;
         if (sel == 7) d = 2;
         if (sel == 8) d = 6;
         if (sel == 9) begin
            wr  = $urandom % 2 == 0;
            pho = wr ? 1 + int'($urandom % 3) : 0;
         end
         w = {$urandom, $urandom};
         m = MASK_W'($urandom);
         run_burst(pho, wr, d, w, m, in_window(d) ? "R4" : "R7");
      end

      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule